// File: doc/BRIEF.md
# Background RAM Clear Sequencer

This block is a nibble-wide simple dual-port memory that can be zeroed without stalling its user. The user sees 1024 locations of 4 bits each, with one write port and one read port. The read port has a registered output and one clock of latency. The same bits are also grouped as 256 words of 16 bits. Each 16-bit word holds four neighbouring nibble locations. A state machine uses these wide words to clear the whole store in 256 write cycles, where a nibble-by-nibble walk would need 1024.

A one-cycle pulse on `clr_req` moves the sequencer from IDLE to CLEARING. In CLEARING it writes zero to one wide word per clock, in ascending order. After the last word it enters DONE for one cycle, then returns to IDLE. The transitions are:
- IDLE -> CLEARING on a request.
- CLEARING -> CLEARING while words remain.
- CLEARING -> DONE on the last word.
- DONE -> IDLE unconditionally.

While the sequencer is in CLEARING, the read register loads zero, so the store already looks empty. User writes are still accepted during the clear. If a user write and the sequencer hit the same wide word in the same cycle, the user's nibble wins. The synchronous reset acts only on the sequencer and on the read register. The stored bits are left untouched.

Top module: `bgclr_ram`

## Requirements
- R1: Reset puts the sequencer in IDLE: `clr_busy` = 0, `clr_done` = 0 and `rd_data` = 0. Reset leaves every stored value unchanged, including when it cuts a clear short.
- R2: A write with `wr_en` = 1 stores `wr_data` at `wr_addr` on the clock edge. `rd_data` shows the value at `rd_addr` one edge after the address is sampled. A read of the address being written in the same edge returns the old value.
- R3: Narrow address `a` lies in wide word `a >> 2`, in nibble lane `a[1:0]`, with lane 0 the least significant nibble. The four lanes of a word are written and read independently.
- R4: A request sampled in IDLE at edge E0 starts the clear. `clr_busy` is 1 from E0 until edge E256, which writes the last word. `clr_done` is 1 for exactly the cycle between E256 and E257. The block is in IDLE after E257.
- R5: Every read sampled while `clr_busy` = 1 loads zero into `rd_data`, whatever the array holds.
- R6: Once a clear finishes, every address reads zero unless it was written after its word was cleared.
- R7: A user write during a clear to a wide word the sequencer has not yet reached is zero once the clear completes.
- R8: A user write during a clear to a wide word already cleared keeps its value.
- R9: A request that arrives in CLEARING or DONE is ignored. The completion time of the running clear is unchanged, and no new clear starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Nibble write enable |
| wr_addr | input | 10 | Nibble write address |
| wr_data | input | 4 | Nibble write data |
| rd_addr | input | 10 | Nibble read address |
| rd_data | output | 4 | Registered read data, zero while clearing |
| clr_req | input | 1 | One-cycle clear request |
| clr_busy | output | 1 | Sequencer is in CLEARING |
| clr_done | output | 1 | Sequencer is in DONE (one cycle) |

## Verification
The bench drives inputs on falling edges and samples on the next falling edge. A read therefore shows up at the first sample after the edge that captured its address.

For a clear requested before edge E0, the sample taken after edge E(c-1) is numbered c:
- `clr_busy` is expected high for samples 1 to 256.
- `clr_done` is expected high only at sample 257.
- The mask is expected on samples 2 to 257, because sample 1 still carries the read taken in IDLE.

User writes and repeated requests are placed at fixed sample numbers. This makes it possible to work out beforehand, from the one-word-per-edge walk, whether each target word has already been cleared.

// File: rtl/bgclr_pkg.sv
package bgclr_pkg;
    typedef enum logic [1:0] {
        CS_IDLE     = 2'd0,
        CS_CLEARING = 2'd1,
        CS_DONE     = 2'd2
    } clr_state_e;
endpackage

// File: rtl/bgclr_seq.sv
module bgclr_seq
    import bgclr_pkg::*;
#(
    parameter int WORDS = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_req,
    output logic                     busy,
    output logic                     done,
    output logic                     wipe_en,
    output logic [$clog2(WORDS)-1:0] wipe_addr
);
    localparam int AW = $clog2(WORDS);
    localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

    clr_state_e      state_q, state_d;
    logic [AW-1:0]   ptr_q, ptr_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            CS_IDLE: begin
                if (clr_req) begin
                    state_d = CS_CLEARING;
                    ptr_d   = '0;
                end
            end
            CS_CLEARING: begin
                if (ptr_q == LAST) begin
                    state_d = CS_DONE;
                end else begin
                    ptr_d = ptr_q + AW'(1);
                end
            end
            CS_DONE: begin
                state_d = CS_IDLE;
            end
            default: begin
                state_d = CS_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q == CS_CLEARING);
        done      = (state_q == CS_DONE);
        wipe_en   = busy;
        wipe_addr = ptr_q;
    end

    p_start_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_IDLE && clr_req) |=> (state_q == CS_CLEARING && ptr_q == '0));

    // R9: requests during the walk do not restart or stall it
    p_walk_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_CLEARING && ptr_q != LAST)
            |=> (state_q == CS_CLEARING && ptr_q == $past(ptr_q) + AW'(1)));

    p_finish_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_CLEARING && ptr_q == LAST) |=> done);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> (state_q == CS_IDLE && !done));
endmodule

// File: rtl/bgclr_store.sv
module bgclr_store #(
    parameter int NW    = 4,
    parameter int LANES = 4,
    parameter int WORDS = 256
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_en,
    input  logic [$clog2(WORDS*LANES)-1:0]        wr_addr,
    input  logic [NW-1:0]                         wr_data,
    input  logic                                  wipe_en,
    input  logic [$clog2(WORDS)-1:0]              wipe_addr,
    input  logic                                  mask,
    input  logic [$clog2(WORDS*LANES)-1:0]        rd_addr,
    output logic [NW-1:0]                         rd_data
);
    localparam int LW  = $clog2(LANES);
    localparam int WW  = NW * LANES;
    localparam int NAW = $clog2(WORDS * LANES);

    logic [WW-1:0] mem [WORDS];
    logic [WW-1:0] rd_word;
    logic [NW-1:0] lane_v [LANES];
    logic [NW-1:0] rd_q;

    // wide wipe first, narrow user write last so it wins on a collision
    always_ff @(posedge clk) begin
        if (wipe_en) begin
            mem[wipe_addr] <= '0;
        end
        if (wr_en) begin
            mem[wr_addr[NAW-1:LW]][int'(wr_addr[LW-1:0]) * NW +: NW] <= wr_data;
        end
    end

    assign rd_word = mem[rd_addr[NAW-1:LW]];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_v[g] = rd_word[g*NW +: NW];
    end

    // read register: reset and mask act here, never on the array
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (mask) begin
            rd_q <= '0;
        end else begin
            rd_q <= lane_v[rd_addr[LW-1:0]];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/bgclr_ram.sv
module bgclr_ram #(
    parameter int NIB_W     = 4,
    parameter int NIB_DEPTH = 1024,
    parameter int LANES     = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [$clog2(NIB_DEPTH)-1:0]  wr_addr,
    input  logic [NIB_W-1:0]              wr_data,
    input  logic [$clog2(NIB_DEPTH)-1:0]  rd_addr,
    output logic [NIB_W-1:0]              rd_data,
    input  logic                          clr_req,
    output logic                          clr_busy,
    output logic                          clr_done
);
    localparam int WORDS = NIB_DEPTH / LANES;
    localparam int WAW   = $clog2(WORDS);

    logic            wipe_en;
    logic [WAW-1:0]  wipe_addr;

    bgclr_seq #(.WORDS(WORDS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .clr_req   (clr_req),
        .busy      (clr_busy),
        .done      (clr_done),
        .wipe_en   (wipe_en),
        .wipe_addr (wipe_addr)
    );

    bgclr_store #(.NW(NIB_W), .LANES(LANES), .WORDS(WORDS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wipe_en   (wipe_en),
        .wipe_addr (wipe_addr),
        .mask      (clr_busy),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    p_mask_r5: assert property (@(posedge clk) disable iff (rst)
        clr_busy |=> (rd_data == '0));

    p_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(clr_busy && clr_done));
endmodule

// File: tb/bgclr_ram_test.sv
`timescale 1ns/1ps
module bgclr_ram_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [9:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic [9:0] rd_addr = '0;
    logic [3:0] rd_data;
    logic       clr_req = 1'b0;
    logic       clr_busy;
    logic       clr_done;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    bgclr_ram uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .clr_req(clr_req), .clr_busy(clr_busy), .clr_done(clr_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [3:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        chk(req, rd_data, exp);
    endtask

    // Sample c follows edge E(c-1); the request is sampled at E0.
    task automatic do_clear(input bit traffic);
        @(negedge clk);
        clr_req = 1'b1; rd_addr = 10'd35;
        for (int c = 1; c <= 259; c++) begin
            @(negedge clk);
            clr_req = 1'b0; wr_en = 1'b0;
            chk("R4 busy", clr_busy, (c <= 256));
            chk("R4 done", clr_done, (c == 257));
            if (c >= 2 && c <= 257) chk("R5 mask", rd_data, 0);
            if (c == 258) chk("R8 kept at 35", rd_data, traffic ? 4'hA : 4'h0);
            if (c == 259) chk("R9 no restart", clr_busy, 0);
            if (traffic) begin
                case (c)
                    10:  begin wr_en = 1'b1; wr_addr = 10'd35;  wr_data = 4'hA; end
                    11:  begin wr_en = 1'b1; wr_addr = 10'd44;  wr_data = 4'hB; end
                    12:  begin wr_en = 1'b1; wr_addr = 10'd803; wr_data = 4'hC; end
                    50:  clr_req = 1'b1;
                    257: clr_req = 1'b1;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic t_reset_state;
        repeat (3) @(negedge clk);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 busy", clr_busy, 0);
        chk("R1 done", clr_done, 0);
        rst = 1'b0;
    endtask

    task automatic t_first_clear;
        do_clear(1'b0);
        for (int a = 0; a < 1024; a++) rd(10'(a), 4'h0, "R6 sweep");
    endtask

    task automatic t_rw;
        wr(10'd7, 4'h3);
        rd(10'd7, 4'h3, "R2 readback");
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 10'd7; wr_data = 4'h5; rd_addr = 10'd7;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2 old data on collision", rd_data, 4'h3);
        rd(10'd7, 4'h5, "R2 new data");
        for (int l = 0; l < 4; l++) wr(10'(40 + l), 4'(l + 9));
        wr(10'd41, 4'h2);
        rd(10'd40, 4'h9, "R3 lane0");
        rd(10'd41, 4'h2, "R3 lane1");
        rd(10'd42, 4'hB, "R3 lane2");
        rd(10'd43, 4'hC, "R3 lane3");
    endtask

    task automatic t_clear_traffic;
        wr(10'd35, 4'h6);
        wr(10'd34, 4'h7);
        wr(10'd44, 4'h1);
        wr(10'd803, 4'h4);
        wr(10'd12, 4'hF);
        do_clear(1'b1);
        rd(10'd35,  4'hA, "R8 write behind walker");
        rd(10'd34,  4'h0, "R3 neighbour lane cleared");
        rd(10'd44,  4'h0, "R7 write ahead of walker");
        rd(10'd803, 4'h0, "R7 far write ahead");
        rd(10'd12,  4'h0, "R6 preloaded cleared");
    endtask

    task automatic t_reset_keeps;
        wr(10'd5, 4'h9);
        rd(10'd5, 4'h9, "R1 pre");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 output zero", rd_data, 0);
        rd(10'd5, 4'h9, "R1 contents kept");
        wr(10'd1000, 4'hD);
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
        repeat (18) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 busy after mid reset", clr_busy, 0);
        chk("R1 done after mid reset", clr_done, 0);
        chk("R1 out after mid reset", rd_data, 0);
        rd(10'd1000, 4'hD, "R1 unreached word kept");
        chk("R1 stays idle", clr_busy, 0);
    endtask

    initial begin
        t_reset_state();
        t_first_clear();
        t_rw();
        t_clear_traffic();
        t_reset_keeps();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule